// File: doc/BRIEF.md
# Serial Configuration Loader with Latched Output and Readback

This block takes a 22-bit configuration word over three serial wires (a serial clock, a data line and a latch-enable line). It turns the word into a parallel configuration vector for a clock-distribution core. Bits are captured into a shift register on the rising edge of the serial clock, but only while latch enable is low. The first bit received ends up in the most significant position. The parallel output does not follow the shift register. It only takes the shift register's contents when latch enable rises, and then it holds that value. So a partly shifted frame never reaches the downstream dividers, enables and output-type selectors. Those consumers split the output vector into fields themselves.

All three serial inputs are slow compared with the core clock. Each one passes through a multi-stage synchronizer and is then edge-detected in the core clock domain. The whole block therefore runs on one clock. A read-data line echoes the top of the shift register. It updates on each falling serial-clock edge, so a host that clocks in a new frame gets the previous frame back, first bit first.

Top module: `scfg_loader`

## Requirements
- R1: While reset is asserted, and right after it, `cfg_o` equals 22'h0000FF (all divider codes 0, meaning divide-by-1, and the eight enable bits in positions 7..0 set) and `ser_rd_o` is 0. The shift register clears to zero.
- R2: Bits are shifted in most significant first. After 22 rising serial-clock edges with latch enable low, followed by a latch, `cfg_o[21]` holds the first bit sent and `cfg_o[0]` holds the last.
- R3: While bits are being shifted and latch enable stays low, `cfg_o` keeps the previously latched word.
- R4: A rising edge on latch enable copies the whole shift register into `cfg_o` within SYNC_STAGES+2 core clock cycles. After that, `cfg_o` holds the value while latch enable stays high.
- R5: Serial-clock edges while latch enable is high do not change the shift register. Lowering latch enable and raising it again re-latches the same word.
- R6: If a frame has more than 22 clocks, the last 22 bits shifted are the ones latched.
- R7: After each falling serial-clock edge, `ser_rd_o` equals the most significant bit of the shift register. That is the bit captured 21 rising edges before the latest one, or 0 if no such bit has been captured since reset.
- R8: A falling edge on latch enable leaves `cfg_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial clock (asynchronous) |
| ser_dat_i | input | 1 | Serial write data (asynchronous) |
| ser_le_i | input | 1 | Latch enable (asynchronous) |
| cfg_o | output | 22 | Active configuration word |
| ser_rd_o | output | 1 | Serial readback data |

## Verification
On every core cycle, the assertions check that a synchronized rising serial-clock edge with latch enable low moves the shift register up by one bit and takes in the synchronized data bit. They also check that latch enable being high freezes the shift register, that `cfg_o` changes only on a latch-enable rising edge and then equals the shift register, and that a falling serial-clock edge loads the readback bit from the top of the register. End-to-end behaviour can only be shown by the bench scenarios. These cover bit order across a whole frame, the reset default, over-length frames, re-latching after clocks sent with latch enable high, and readback of an earlier frame while a new one is being sent.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
   localparam int unsigned CFG_W_DEF = 22;
   // divider codes 0 (divide-by-1), enables in the low byte all set
   localparam logic [CFG_W_DEF-1:0] CFG_RESET_DEF = 22'h0000FF;
   localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_chk_stages
      $error("scfg_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_chk_w
      $error("scfg_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stg_q[s] <= '0;
         end else begin
            if (s == 0) stg_q[s] <= d_i;
            else        stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
   parameter int unsigned W          = 22,
   parameter bit          RD_ON_FALL = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         shift_i,
   input  logic         dat_i,
   input  logic         sclk_rise_i,
   input  logic         sclk_fall_i,
   output logic [W-1:0] sh_o,
   output logic         rd_o
);
   if (W < 2) begin : g_chk_w
      $error("scfg_shifter: W must be at least 2");
   end

   logic [W-1:0] sh_q;
   logic         rd_q;
   logic         rd_upd;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sh_q <= '0;
      else if (shift_i) sh_q <= {sh_q[W-2:0], dat_i};
   end

   if (RD_ON_FALL) begin : g_rd_fall
      assign rd_upd = sclk_fall_i;
   end else begin : g_rd_rise
      assign rd_upd = sclk_rise_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rd_q <= 1'b0;
      else if (rd_upd) rd_q <= sh_q[W-1];
   end

   assign sh_o = sh_q;
   assign rd_o = rd_q;
endmodule

// File: rtl/scfg_latch.sv
module scfg_latch #(
   parameter int unsigned     W     = 22,
   parameter logic [W-1:0]    RESET = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] act_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     act_q <= RESET;
      else if (load_i) act_q <= d_i;
   end

   assign q_o = act_q;
endmodule

// File: rtl/scfg_loader.sv
module scfg_loader #(
   parameter int unsigned            CFG_W       = scfg_pkg::CFG_W_DEF,
   parameter logic [CFG_W-1:0]       CFG_RESET   = scfg_pkg::CFG_RESET_DEF,
   parameter int unsigned            SYNC_STAGES = scfg_pkg::SYNC_STAGES_DEF,
   parameter bit                     RD_ON_FALL  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ser_clk_i,
   input  logic             ser_dat_i,
   input  logic             ser_le_i,
   output logic [CFG_W-1:0] cfg_o,
   output logic             ser_rd_o
);
   localparam int unsigned IN_W   = 3;
   localparam int unsigned IDX_CK = 0;
   localparam int unsigned IDX_DT = 1;
   localparam int unsigned IDX_LE = 2;

   if (CFG_W < 2) begin : g_chk_w
      $error("scfg_loader: CFG_W must be at least 2");
   end

   logic [IN_W-1:0]  raw_in, syn_in;
   logic             sclk_s, dat_s, le_s;
   logic             sclk_q, le_q;
   logic             sclk_rise, sclk_fall, le_rise, shift_en;
   logic [CFG_W-1:0] sh_w;

   assign raw_in = {ser_le_i, ser_dat_i, ser_clk_i};

   scfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   assign sclk_s = syn_in[IDX_CK];
   assign dat_s  = syn_in[IDX_DT];
   assign le_s   = syn_in[IDX_LE];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_q <= 1'b0;
         le_q   <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         le_q   <= le_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_q;
   assign sclk_fall = ~sclk_s & sclk_q;
   assign le_rise   = le_s & ~le_q;
   assign shift_en  = sclk_rise & ~le_s;

   scfg_shifter #(.W(CFG_W), .RD_ON_FALL(RD_ON_FALL)) shift_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_i    (shift_en),
      .dat_i      (dat_s),
      .sclk_rise_i(sclk_rise),
      .sclk_fall_i(sclk_fall),
      .sh_o       (sh_w),
      .rd_o       (ser_rd_o)
   );

   scfg_latch #(.W(CFG_W), .RESET(CFG_RESET)) latch_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(le_rise),
      .d_i   (sh_w),
      .q_o   (cfg_o)
   );

   // R2: a qualified rising serial edge moves the register up and appends data
   p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sclk_rise && !le_s) |=> (sh_w == {$past(sh_w[CFG_W-2:0]), $past(dat_s)}));

   // R5: latch enable high freezes the shift register
   p_le_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      le_s |=> $stable(sh_w));

   // R4: latch-enable rising edge copies the shift register to the output
   p_latch_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      le_rise |=> (cfg_o == $past(sh_w)));

   // R3, R8: output moves only on a latch-enable rising edge
   p_cfg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !le_rise |=> $stable(cfg_o));

   // R7: falling serial edge presents the register top bit
   if (RD_ON_FALL) begin : g_rd_chk
      p_rd_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         sclk_fall |=> (ser_rd_o == $past(sh_w[CFG_W-1])));
   end

   // R7: readback is steady between falling edges
   p_rd_steady_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(RD_ON_FALL ? sclk_fall : sclk_rise) |=> $stable(ser_rd_o));
endmodule

// File: tb/scfg_loader_tb.sv
module scfg_loader_tb_top;
   localparam int W = 22;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sclk = 1'b0;
   logic         sdat = 1'b0;
   logic         sle  = 1'b0;
   logic [W-1:0] cfg;
   logic         rd;

   always #5 clk = ~clk;

   scfg_loader dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .ser_clk_i(sclk),
      .ser_dat_i(sdat),
      .ser_le_i (sle),
      .cfg_o    (cfg),
      .ser_rd_o (rd)
   );

   typedef struct {
      bit           is_cfg;
      logic [W-1:0] val;
      string        tag;
   } exp_t;

   exp_t         sb_q[$];
   int           n_vec = 0;
   int           n_bad = 0;
   bit           done  = 1'b0;
   logic [W-1:0] m_sh  = '0;
   logic [W-1:0] m_cfg = 22'h0000FF;
   bit           m_le  = 1'b0;

   // monitor: compare queued expectations against the outputs
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (e.is_cfg) begin
               if (cfg !== e.val) begin
                  n_bad++;
                  $display("FAIL %s cfg_o actual=%h expected=%h", e.tag, cfg, e.val);
               end
            end else if (rd !== e.val[0]) begin
               n_bad++;
               $display("FAIL %s ser_rd_o actual=%b expected=%b", e.tag, rd, e.val[0]);
            end
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic exp_cfg(input logic [W-1:0] v, input string tag);
      exp_t e;
      e.is_cfg = 1'b1; e.val = v; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic exp_rd(input logic b, input string tag);
      exp_t e;
      e.is_cfg = 1'b0; e.val = '0; e.val[0] = b; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic ser_bit(input logic b);
      sdat = b;
      wait_clk(6);
      sclk = 1'b1;
      if (!m_le) m_sh = {m_sh[W-2:0], b};
      wait_clk(6);
      sclk = 1'b0;
      wait_clk(6);
      exp_rd(m_sh[W-1], "R7 readback");
   endtask

   task automatic send(input logic [63:0] v, input int n, input string tag);
      for (int i = n - 1; i >= 0; i--) begin
         ser_bit(v[i]);
         if (i == n / 2) exp_cfg(m_cfg, {tag, " R3 hold mid-frame"});
      end
   endtask

   task automatic latch(input string tag);
      sle = 1'b1; m_le = 1'b1;
      m_cfg = m_sh;
      wait_clk(8);
      exp_cfg(m_cfg, {tag, " R4 latched"});
      wait_clk(4);
      sle = 1'b0; m_le = 1'b0;
      wait_clk(8);
      exp_cfg(m_cfg, {tag, " R8 le fall no change"});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wait_clk(5);
      exp_cfg(22'h0000FF, "R1 default during reset");
      exp_rd(1'b0, "R1 readback during reset");
      wait_clk(1);
      rst_n = 1'b1;
      m_sh = '0; m_cfg = 22'h0000FF; m_le = 1'b0;
      wait_clk(3);
      exp_cfg(22'h0000FF, "R1 default after reset");
   endtask

   initial begin
      do_reset();

      // R2: MSB-first full frame, explicit end bits checked too
      send(64'h2A5C3F, W, "R2 frame A");
      latch("R2 frame A");
      wait_clk(1);
      if (cfg[W-1] !== 1'b1 || cfg[0] !== 1'b1) begin
         n_bad++;
         $display("FAIL R2 end bits actual=%b%b expected=11", cfg[W-1], cfg[0]);
      end
      n_vec++;

      // R7: new frame pulls frame A back out, frame B latched
      send(64'h1FFFFF, W, "R7 frame B");
      latch("R2 frame B");

      // R5: clocks with latch enable high do not shift
      sle = 1'b1; m_le = 1'b1;
      wait_clk(8);
      send(64'h15, 5, "R5 le high");
      sle = 1'b0; m_le = 1'b0;
      wait_clk(8);
      latch("R5 relatch");
      exp_cfg(22'h1FFFFF, "R5 same word");

      // R6: over-length frame keeps the last 22 bits
      send(64'h3F_0123_4567, 30, "R6 long");
      latch("R6 long");
      exp_cfg(22'h234567, "R6 last 22 bits");

      // all-zero frame
      send(64'h0, W, "R2 zero");
      latch("R2 zero");
      exp_cfg(22'h000000, "R2 zero word");

      // R1: reset mid-operation restores default
      send(64'h3, 2, "R1 partial");
      do_reset();

      wait_clk(4);
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         n_vec++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule